// File: doc/BRIEF.md
# Instruction Prefetch Unit

The block keeps the execution stage supplied with instruction words without borrowing the ALU. A 16-bit fetch counter, with its own incrementer, holds the address of the next word to fetch. It steps by one word for every fetch the memory side accepts. Its value changes in only two other ways: reset, or a redirect carrying a jump or branch target. Software never writes it.

Returned instruction words enter a small in-order queue, two entries deep by default. The head of the queue is always the next instruction to execute. When execution consumes the head, the second entry moves up. The unit raises a fetch request whenever the queue has a free entry. A returned word flagged as an immediate operand goes into a separate operand register and never enters the queue. A redirect loads the counter with the target and empties the queue in the same cycle.

Top module: `ifq_prefetch`

## Requirements
- R1: While reset is asserted and after it is released, `fetch_addr` is 0x0000, `instr_valid` is 0, `imm_word` is 0x0000 and `fetch_req` is 1.
- R2: A fetch is accepted in a cycle where `fetch_req` and `fetch_valid` are both 1 and `redirect_valid` is 0. `fetch_addr` then rises by exactly one on the following clock edge.
- R3: The fetch counter wraps from 0xFFFF to 0x0000 on an accepted fetch.
- R4: `redirect_valid` loads `fetch_addr` with `redirect_target` on the next edge and empties the queue (`instr_valid` becomes 0). A fetch response or consume in the same cycle is discarded.
- R5: A non-immediate word from an accepted fetch (`fetch_imm` = 0) is stored in the queue in arrival order. The first such word into an empty queue appears on `instr_word` with `instr_valid` = 1 one cycle later.
- R6: `consume` while `instr_valid` is 1 removes the head, and the second entry becomes the head on the next edge.
- R7: `fetch_req` is 0 exactly when the queue is full. A `fetch_valid` while `fetch_req` is 0 changes neither the counter nor the queue.
- R8: A word from an accepted fetch with `fetch_imm` = 1 is loaded into `imm_word` and does not enter the queue, while the counter still advances.
- R9: `consume` while the queue is empty has no effect.
- R10: A consume and an accepted non-immediate fetch in the same cycle with one entry held leave the new word as the sole head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| redirect_valid | input | 1 | Jump or branch load request |
| redirect_target | input | 16 | New fetch address for a redirect |
| fetch_valid | input | 1 | Memory returns a word for `fetch_addr` this cycle |
| fetch_data | input | 16 | Returned word |
| fetch_imm | input | 1 | Returned word is an immediate operand |
| consume | input | 1 | Execution takes the head instruction |
| fetch_req | output | 1 | A queue entry is free; a fetch is wanted |
| fetch_addr | output | 16 | Address of the next word to fetch |
| instr_valid | output | 1 | Queue head is valid |
| instr_word | output | 16 | Next instruction to execute |
| imm_word | output | 16 | Most recent immediate operand |

## Verification
Every result is due exactly one edge after its stimulus, because the counter, the queue and the operand register are all plain registers. `fetch_req` follows the queue occupancy combinationally, so it also settles one edge after the fetch or consume that changed it. The bench drives inputs on a falling edge and samples on the next falling edge, half a period after the edge that updates state. Reset release waits out the two-stage synchronizer before any vector is applied.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifq_rst_sync.sv
module ifq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/ifq_counter.sv
module ifq_counter
  import ifq_pkg::*;
#(
  parameter word_t RESET_VEC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t target,
  input  logic  step,
  output word_t addr
);
  word_t pc_q, pc_d;
  logic  pc_en;

  always_comb begin
    pc_en = load | step;
    pc_d  = pc_q;
    if (load)      pc_d = target;
    else if (step) pc_d = pc_q + word_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign addr = pc_q;
endmodule

// File: rtl/ifq_queue.sv
module ifq_queue
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  push,
  input  word_t push_data,
  input  logic  pop_req,
  output logic  full,
  output logic  nonempty,
  output word_t head
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wr_idx;
  word_t         ent_q [DEPTH];
  word_t         ent_d [DEPTH];
  logic          pop;
  logic          ent_en;

  always_comb begin
    pop    = pop_req && (cnt_q != '0);
    wr_idx = cnt_q - CW'(pop);
    ent_en = !flush && (pop || push);
    cnt_d  = cnt_q;
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    if (flush) begin
      cnt_d = '0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (wr_idx == CW'(i))) ent_d[i] = push_data;
      end
      cnt_d = cnt_q - CW'(pop) + CW'(push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (ent_en) ent_q[g] <= ent_d[g];
      end
    end
  endgenerate

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign head     = ent_q[0];
endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH     = 2,
  parameter word_t       RESET_VEC = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        redirect_valid,
  input  logic [15:0] redirect_target,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_data,
  input  logic        fetch_imm,
  input  logic        consume,
  output logic        fetch_req,
  output logic [15:0] fetch_addr,
  output logic        instr_valid,
  output logic [15:0] instr_word,
  output logic [15:0] imm_word
);
  logic  rst_int_n;
  logic  q_full;
  logic  accept;
  logic  push;
  logic  imm_en;
  word_t imm_q;

  ifq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    accept = fetch_req && fetch_valid && !redirect_valid;
    push   = accept && !fetch_imm;
    imm_en = accept && fetch_imm;
  end

  ifq_counter #(.RESET_VEC(RESET_VEC)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (redirect_valid),
    .target (redirect_target),
    .step   (accept),
    .addr   (fetch_addr)
  );

  ifq_queue #(.DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (redirect_valid),
    .push      (push),
    .push_data (fetch_data),
    .pop_req   (consume),
    .full      (q_full),
    .nonempty  (instr_valid),
    .head      (instr_word)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  imm_q <= '0;
    else if (imm_en) imm_q <= fetch_data;
  end

  assign fetch_req = !q_full;
  assign imm_word  = imm_q;
endmodule

// File: rtl/ifq_prefetch_chk.sv
module ifq_prefetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        redirect_valid,
  input logic [15:0] redirect_target,
  input logic        fetch_valid,
  input logic [15:0] fetch_data,
  input logic        fetch_imm,
  input logic        fetch_req,
  input logic [15:0] fetch_addr,
  input logic        instr_valid,
  input logic [15:0] imm_word
);
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_valid && !redirect_valid) |=>
      (fetch_addr == 16'($past(fetch_addr) + 16'd1)));

  a_r4_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (fetch_addr == $past(redirect_target)) && !instr_valid);

  a_r7_no_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !redirect_valid) |=> $stable(fetch_addr));

  a_r7_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> instr_valid);

  a_r8_imm_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_valid && fetch_imm && !redirect_valid) |=>
      (imm_word == $past(fetch_data)));

  a_r9_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !(fetch_req && fetch_valid && !fetch_imm)) |=> !instr_valid);
endmodule

bind ifq_prefetch ifq_prefetch_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_int_n),
  .redirect_valid  (redirect_valid),
  .redirect_target (redirect_target),
  .fetch_valid     (fetch_valid),
  .fetch_data      (fetch_data),
  .fetch_imm       (fetch_imm),
  .fetch_req       (fetch_req),
  .fetch_addr      (fetch_addr),
  .instr_valid     (instr_valid),
  .imm_word        (imm_word)
);

// File: tb/tb_ifq_prefetch.sv
`timescale 1ns/1ps
module tb_ifq_prefetch;
  typedef struct packed {
    logic        rd;
    logic [15:0] tg;
    logic        fv;
    logic        fi;
    logic [15:0] fd;
    logic        cs;
    logic [15:0] ea;
    logic        ev;
    logic [15:0] ew;
    logic        er;
    logic [15:0] ei;
  } vec_t;

  localparam int NV = 12;
  // rd  tg        fv   fi   fd        cs   ea        ev   ew        er   ei
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hA100, 1'b0, 16'h0001, 1'b1, 16'hA100, 1'b1, 16'h0000}, // R2 R5
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hA101, 1'b0, 16'h0002, 1'b1, 16'hA100, 1'b0, 16'h0000}, // R5 R7 full
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hBEEF, 1'b0, 16'h0002, 1'b1, 16'hA100, 1'b0, 16'h0000}, // R7 ignored
    '{1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0002, 1'b1, 16'hA101, 1'b1, 16'h0000}, // R6 shift
    '{1'b0, 16'h0000, 1'b1, 1'b1, 16'h1234, 1'b0, 16'h0003, 1'b1, 16'hA101, 1'b1, 16'h1234}, // R8 imm
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hA103, 1'b1, 16'h0004, 1'b1, 16'hA103, 1'b1, 16'h1234}, // R10
    '{1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0004, 1'b0, 16'h0000, 1'b1, 16'h1234}, // R6 drain
    '{1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0004, 1'b0, 16'h0000, 1'b1, 16'h1234}, // R9 empty
    '{1'b1, 16'hFFFE, 1'b1, 1'b0, 16'hDEAD, 1'b0, 16'hFFFE, 1'b0, 16'h0000, 1'b1, 16'h1234}, // R4 drop
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hC000, 1'b0, 16'hFFFF, 1'b1, 16'hC000, 1'b1, 16'h1234}, // R2
    '{1'b0, 16'h0000, 1'b1, 1'b0, 16'hC001, 1'b0, 16'h0000, 1'b1, 16'hC000, 1'b0, 16'h1234}, // R3 wrap
    '{1'b1, 16'h0040, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0040, 1'b0, 16'h0000, 1'b1, 16'h1234}  // R4 flush
  };

  logic        clk;
  logic        rst_n;
  logic        redirect_valid;
  logic [15:0] redirect_target;
  logic        fetch_valid;
  logic [15:0] fetch_data;
  logic        fetch_imm;
  logic        consume;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic [15:0] imm_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ifq_prefetch dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .fetch_valid     (fetch_valid),
    .fetch_data      (fetch_data),
    .fetch_imm       (fetch_imm),
    .consume         (consume),
    .fetch_req       (fetch_req),
    .fetch_addr      (fetch_addr),
    .instr_valid     (instr_valid),
    .instr_word      (instr_word),
    .imm_word        (imm_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    redirect_valid  = 1'b0;
    redirect_target = '0;
    fetch_valid     = 1'b0;
    fetch_data      = '0;
    fetch_imm       = 1'b0;
    consume         = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    chk("R1", {tag, " fetch_addr"}, fetch_addr, 16'h0000);
    chk("R1", {tag, " instr_valid"}, 16'(instr_valid), 16'h0000);
    chk("R1", {tag, " imm_word"}, imm_word, 16'h0000);
    chk("R1", {tag, " fetch_req"}, 16'(fetch_req), 16'h0001);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    #1;
    check_reset_state("in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("after release");
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      redirect_valid  = TBL[i].rd;
      redirect_target = TBL[i].tg;
      fetch_valid     = TBL[i].fv;
      fetch_imm       = TBL[i].fi;
      fetch_data      = TBL[i].fd;
      consume         = TBL[i].cs;
      @(negedge clk);
      chk("R2/R3/R4", $sformatf("vec %0d fetch_addr", i), fetch_addr, TBL[i].ea);
      chk("R4/R5/R6/R9", $sformatf("vec %0d instr_valid", i), 16'(instr_valid), 16'(TBL[i].ev));
      if (TBL[i].ev)
        chk("R5/R6/R10", $sformatf("vec %0d instr_word", i), instr_word, TBL[i].ew);
      chk("R7", $sformatf("vec %0d fetch_req", i), 16'(fetch_req), 16'(TBL[i].er));
      chk("R8", $sformatf("vec %0d imm_word", i), imm_word, TBL[i].ei);
    end
    idle_inputs();

    // Directed R2: four back-to-back fetches with one consume each keep order.
    for (int k = 0; k < 4; k++) begin
      fetch_valid = 1'b1;
      fetch_data  = 16'h5000 + 16'(k);
      consume     = (k != 0);
      @(negedge clk);
      chk("R2", $sformatf("burst %0d addr", k), fetch_addr, 16'h0041 + 16'(k));
      chk("R5", $sformatf("burst %0d head", k), instr_word, 16'h5000 + 16'(k));
    end
    idle_inputs();

    // Directed R1: asynchronous reset in the middle of activity.
    fetch_valid = 1'b1;
    fetch_imm   = 1'b1;
    fetch_data  = 16'h7777;
    @(negedge clk);
    chk("R8", "imm before reset", imm_word, 16'h7777);
    do_reset();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule